// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block forms the read data of a byte-wide nonvolatile memory. While an internal programming cycle runs, every read is a status poll rather than an array read: the top data bit returns the inverse of the top bit of the last byte written, and the bit below it flips on each new read access. The remaining low bits return the latched last-written byte. When programming finishes, the path returns the true array contents on all bits, and the flipping bit stops.

The three active-low strobes (chip-enable, output-enable, write-enable) come from the pins and are asynchronous. They are brought into the clock domain by a synchronizer before use. A read access begins when the synchronized strobes enter the read state: chip-enable and output-enable both low, with write-enable high. This can happen by lowering either enable last, or both together. The programming-busy flag, the latched last byte and the array read data are synchronous to the clock. The outputs are registered: a data byte and an output-enable for the tri-state pad driver.

Top module: `wr_status_rdpath`

## Requirements
- R1: While reset is high, and on the first clock after it, `dq_oe_o` is 0 and `dq_o` is all zeros.
- R2: `dq_oe_o` is 1 only while the synchronized strobes show chip-enable low, output-enable low and write-enable high. When `dq_oe_o` is 0, `dq_o` is all zeros.
- R3: When not busy, a read returns `arr_rdata_i` on all bits.
- R4: When busy, `dq_o[7]` returns the inverse of `last_byte_i[7]`.
- R5: When busy, `dq_o[5:0]` returns `last_byte_i[5:0]`.
- R6: When busy, `dq_o[6]` changes value on each new read access. This holds whether the access begins by output-enable falling, by chip-enable falling, or by both falling together.
- R7: The toggle state is cleared when busy rises. The first read access of each programming cycle therefore shows `dq_o[6]` = 1, and reads made while idle do not affect it.
- R8: When busy falls during a read access that is still held, true array data appears on the next registered output, without a new access.
- R9: A strobe change is reflected at the outputs after the third rising clock edge that follows it: two synchronizer stages and one output register.
- R10: An access with write-enable low is not a read. It does not drive the bus and does not advance the toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Chip-enable strobe, active low, asynchronous |
| oe_n_i | input | 1 | Output-enable strobe, active low, asynchronous |
| we_n_i | input | 1 | Write-enable strobe, active low, asynchronous |
| busy_i | input | 1 | Internal programming cycle in progress |
| last_byte_i | input | DATA_W | Latched last byte written |
| arr_rdata_i | input | DATA_W | Array read data for the current address |
| dq_o | output | DATA_W | Registered read data |
| dq_oe_o | output | 1 | Registered tri-state drive enable |

## Verification
Random accesses mix three ways of opening a read: output-enable falling last, chip-enable falling last, and both falling together. Because the toggle bit must advance for each of them, this separates a design that only watches one strobe from one that watches the combined read state. Accesses with write-enable low are interleaved between polls, and the next poll's bit 6 exposes any toggle advance they caused. A new busy period starting after reads made while idle shows whether the toggle is cleared at the cycle start. A read held open across the fall of busy shows whether true data returns without waiting for a new access.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  typedef enum logic [1:0] {
    SRC_OFF    = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2
  } rd_src_e;
endpackage

// File: rtl/wcs_sync.sv
module wcs_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d_i;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];

  // The last stage only takes a value that the stage before it held.
  p_chain_r9: assert property (@(posedge clk) disable iff (rst)
    (STAGES > 1) && !$past(rst) |-> q_o == $past(stg[(STAGES > 1) ? STAGES-2 : 0]));
endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic rd_start_i,
  output logic tog_next_o
);
  logic busy_q;
  logic tog_q;
  logic busy_rise;
  logic tog_base;

  assign busy_rise  = busy_i & ~busy_q;
  assign tog_base   = busy_rise ? 1'b0 : tog_q;
  assign tog_next_o = tog_base ^ (rd_start_i & busy_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      tog_q  <= tog_next_o;
    end
  end

  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (rst)
    busy_i && !busy_q && !rd_start_i |=> !tog_q);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_start_i && !(busy_i && !busy_q) |=> $stable(tog_q));
  p_flip_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    rd_start_i && busy_i && busy_q |=> tog_q != $past(tog_q));
endmodule

// File: rtl/wcs_outmux.sv
module wcs_outmux
  import wcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rd_src_e           src_i,
  input  logic [DATA_W-1:0] arr_i,
  input  logic [DATA_W-1:0] last_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] dq_d;

  always_comb begin
    status_w           = last_i;
    status_w[POLL_BIT] = ~last_i[POLL_BIT];
    status_w[TOG_BIT]  = tog_i;
  end

  always_comb begin
    unique case (src_i)
      SRC_ARRAY:  dq_d = arr_i;
      SRC_STATUS: dq_d = status_w;
      default:    dq_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      dq_o    <= dq_d;
      dq_oe_o <= (src_i != SRC_OFF);
    end
  end

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !dq_oe_o |-> dq_o == '0);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> !dq_oe_o && dq_o == '0);
endmodule

// File: rtl/wr_status_rdpath.sv
module wr_status_rdpath
  import wcs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] last_byte_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;
  localparam int NSTRB    = 3;

  logic [NSTRB-1:0] strb_s;
  logic             rd_s;
  logic             rd_q;
  logic             rd_start;
  logic             tog_next;
  rd_src_e          src;

  wcs_sync #(.STAGES(SYNC_STAGES), .W(NSTRB), .RST_VAL('1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({we_n_i, oe_n_i, ce_n_i}),
    .q_o (strb_s)
  );

  // read state: both enables low, write-enable high
  assign rd_s     = ~strb_s[0] & ~strb_s[1] & strb_s[2];
  assign rd_start = rd_s & ~rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_s;
  end

  wcs_toggle u_tog (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .rd_start_i (rd_start),
    .tog_next_o (tog_next)
  );

  always_comb begin
    if (!rd_s)       src = SRC_OFF;
    else if (busy_i) src = SRC_STATUS;
    else             src = SRC_ARRAY;
  end

  wcs_outmux #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .src_i   (src),
    .arr_i   (arr_rdata_i),
    .last_i  (last_byte_i),
    .tog_i   (tog_next),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  p_poll_bit_r4: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o && !$past(rst) && $past(busy_i) |-> dq_o[POLL_BIT] != $past(last_byte_i[POLL_BIT]));
  p_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o && !$past(rst) && $past(busy_i) |-> dq_o[TOG_BIT-1:0] == $past(last_byte_i[TOG_BIT-1:0]));
  p_true_data_r3: assert property (@(posedge clk) disable iff (rst)
    dq_oe_o && !$past(rst) && !$past(busy_i) |-> dq_o == $past(arr_rdata_i));
  p_back_to_data_r8: assert property (@(posedge clk) disable iff (rst)
    rd_s && rd_q && !busy_i && $past(busy_i) |=> dq_oe_o && dq_o == $past(arr_rdata_i));
  p_no_drive_on_write_r10: assert property (@(posedge clk) disable iff (rst)
    !strb_s[2] |=> !dq_oe_o);
endmodule

// File: tb/wr_status_rdpath_tb.sv
module wr_status_rdpath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [DW-1:0] last_b = '0, arr = '0;
  logic [DW-1:0] dq;
  logic          dq_oe;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic exp_tog = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_status_rdpath #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .busy_i(busy), .last_byte_i(last_b), .arr_rdata_i(arr),
    .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] status_of(logic [DW-1:0] lb, logic t);
    logic [DW-1:0] s;
    s = lb;
    s[7] = ~lb[7];
    s[6] = t;
    return s;
  endfunction

  task automatic check(string req, logic [DW-1:0] act_d, logic act_oe,
                       logic [DW-1:0] exp_d, logic exp_oe);
    n_vec++;
    if (act_d !== exp_d || act_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s: dq=%h oe=%b expected dq=%h oe=%b", req, act_d, act_oe, exp_d, exp_oe);
    end
  endtask

  task automatic set_busy(logic b);
    @(negedge clk);
    if (b && !busy) exp_tog = 1'b0;
    busy = b;
  endtask

  // method 0: both fall together, 1: oe falls last, 2: ce falls last
  task automatic open_access(int method, logic we);
    @(negedge clk);
    we_n = we;
    if (method == 1) ce_n = 1'b0;
    if (method == 2) oe_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b0;
    oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic close_access(string req);
    ce_n = 1'b1;
    oe_n = 1'b1;
    we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req, dq, dq_oe, '0, 1'b0);
  endtask

  task automatic do_access(int method, logic we, string req);
    logic [DW-1:0] e;
    open_access(method, we);
    if (!we) begin
      check({req, "/R10"}, dq, dq_oe, '0, 1'b0);
    end else begin
      if (busy) begin
        exp_tog = ~exp_tog;
        e = status_of(last_b, exp_tog);
      end else begin
        e = arr;
      end
      check(req, dq, dq_oe, e, 1'b1);
    end
    close_access("R2 release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_2a1c;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", dq, dq_oe, '0, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", dq, dq_oe, '0, 1'b0);

    // R9 latency: output not yet driven after two edges, driven after third
    arr = 8'h3c;
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R9 before third edge", dq, dq_oe, '0, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R9/R3 at third edge", dq, dq_oe, 8'h3c, 1'b1);
    close_access("R2 R9 release");

    // directed: idle reads, then start of busy clears toggle (R7)
    do_access(0, 1'b1, "R3 idle read");
    last_b = 8'hd5;
    set_busy(1'b1);
    do_access(1, 1'b1, "R7 first poll oe-last");
    do_access(2, 1'b1, "R6 ce-last poll");
    do_access(0, 1'b0, "write-enable low");
    do_access(0, 1'b1, "R6 R10 both-fall poll");
    last_b = 8'h2a;
    do_access(1, 1'b1, "R4 R5 poll");

    // R8: busy drops during a held read
    open_access(2, 1'b1);
    exp_tog = ~exp_tog;
    check("R6 held poll", dq, dq_oe, status_of(last_b, exp_tog), 1'b1);
    arr = 8'h81;
    busy = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 true data after busy fall", dq, dq_oe, 8'h81, 1'b1);
    arr = 8'h7e;
    @(posedge clk); @(negedge clk);
    check("R3 data follows array", dq, dq_oe, 8'h7e, 1'b1);
    close_access("R2 release");

    // R7: new cycle after idle reads starts toggle at 1 again
    do_access(1, 1'b1, "R3 idle read");
    set_busy(1'b1);
    do_access(0, 1'b1, "R7 restart");
    set_busy(1'b0);

    // random
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) set_busy(~busy);
      @(negedge clk);
      last_b = DW'($urandom);
      arr    = DW'($urandom);
      do_access($urandom_range(0, 2), ($urandom_range(0, 5) != 0),
                busy ? "R4 R5 R6 random poll" : "R3 random read");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule